// File: doc/BRIEF.md
# Sleep-Mode Entry/Exit Sequencer

This block manages the low-power sleep state of a synchronous SRAM model. A sleep request arrives from outside the clock domain. The block first aligns it to the clock with a two-stage synchroniser. Sleep then begins a fixed number of cycles after the synchronised request rises, and it ends a fixed number of cycles after the request falls. After sleep ends, a recovery window keeps new accesses from starting.

The sequencer sits between the command decode and the memory array. It watches the combined chip select and both address strobes. It forwards an access to the array only while the device is fully awake. A command that arrives while access is inhibited never reaches the array, so the stored contents stay intact. The block also records a protocol error when the access rules are broken. This covers a selection made while sleep is being entered, and an access started while asleep or during recovery. The error flag holds until reset.

Top module: `sleep_sequencer`

## Requirements
- R1: After reset, `asleep`, `access_block` and `proto_err` are all 0.
- R2: While awake and not inhibited, `cmd_pass` equals `chip_sel & (strobe_a | strobe_b)`, with no delay.
- R3: With default latencies, `asleep` rises on the fourth rising clock edge after `sleep_req` goes high. The first two edges are spent in the synchroniser and the last two in entry.
- R4: With default latencies, `asleep` falls on the fourth rising clock edge after `sleep_req` goes low.
- R5: `access_block` goes high on the third rising edge after `sleep_req` rises, while entry is in progress. It stays high through sleep and recovery. `cmd_pass` is 0 whenever `access_block` is 1.
- R6: After `asleep` falls, `access_block` stays high for `RECOVERY_CYCLES` clock cycles and then returns to 0.
- R7: If `chip_sel` and either strobe are both high while asleep or in recovery, `proto_err` is set at the next rising edge.
- R8: If `chip_sel` is high during the entry cycles, `proto_err` is set at the next rising edge.
- R9: `proto_err` stays at 1 until reset, even after the offending inputs are removed.
- R10: While asleep, `chip_sel` with both strobes low does not set `proto_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| chip_sel | input | 1 | Combined chip select, active high |
| strobe_a | input | 1 | First address strobe, active high |
| strobe_b | input | 1 | Second address strobe, active high |
| asleep | output | 1 | Sleep status |
| access_block | output | 1 | New accesses inhibited |
| cmd_pass | output | 1 | Access forwarded to the array |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The bench keeps the default entry and exit latencies of two cycles and sets `RECOVERY_CYCLES` to 3. This makes the recovery window longer than the exit latency, so a design that reused the exit count for recovery would release `access_block` one cycle early and be caught. Each error case starts from a fresh reset. This lets the entry-window selection rule, the recovery-window strobe rule and the harmless chip-select-only case each be seen on its own against the sticky flag.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    ST_AWAKE = 3'd0,
    ST_ENTER = 3'd1,
    ST_SLEEP = 3'd2,
    ST_EXIT  = 3'd3,
    ST_RECOV = 3'd4
  } slp_state_e;

  // count reaches its final cycle when it is one
  function automatic logic cnt_last(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  // an access attempt: selected and strobed
  function automatic logic is_access(input logic cs, input logic sa, input logic sb);
    return cs & (sa | sb);
  endfunction
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import sleep_seq_pkg::*;
#(
  parameter int ENTRY_CYCLES    = 2,
  parameter int EXIT_CYCLES     = 2,
  parameter int RECOVERY_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sync,
  output slp_state_e state
);
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] REC_LOAD   = CNT_W'(RECOVERY_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_AWAKE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_AWAKE: if (req_sync) begin
          state <= ST_ENTER;
          cnt   <= ENTRY_LOAD;
        end
        ST_ENTER: if (cnt_last(cnt)) state <= ST_SLEEP;
                  else               cnt   <= cnt_dec(cnt);
        ST_SLEEP: if (!req_sync) begin
          state <= ST_EXIT;
          cnt   <= EXIT_LOAD;
        end
        ST_EXIT:  if (cnt_last(cnt)) begin
          state <= ST_RECOV;
          cnt   <= REC_LOAD;
        end else cnt <= cnt_dec(cnt);
        ST_RECOV: if (cnt_last(cnt)) state <= ST_AWAKE;
                  else               cnt   <= cnt_dec(cnt);
        default: begin
          state <= ST_AWAKE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/slp_guard.sv
module slp_guard
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e state,
  input  logic       chip_sel,
  input  logic       strobe_a,
  input  logic       strobe_b,
  output logic       cmd_pass,
  output logic       viol_now,
  output logic       proto_err
);
  logic attempt;
  logic entering;
  logic inhibited;

  assign attempt   = is_access(chip_sel, strobe_a, strobe_b);
  assign entering  = (state == ST_ENTER);
  assign inhibited = (state == ST_SLEEP) || (state == ST_EXIT) || (state == ST_RECOV);
  assign cmd_pass  = attempt && (state == ST_AWAKE);
  assign viol_now  = (entering && chip_sel) || (inhibited && attempt);

  always_ff @(posedge clk) begin
    if (!rst_n)        proto_err <= 1'b0;
    else if (viol_now) proto_err <= 1'b1;
  end
endmodule

// File: rtl/sleep_sequencer.sv
module sleep_sequencer
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int ENTRY_CYCLES    = 2,
  parameter int EXIT_CYCLES     = 2,
  parameter int RECOVERY_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic chip_sel,
  input  logic strobe_a,
  input  logic strobe_b,
  output logic asleep,
  output logic access_block,
  output logic cmd_pass,
  output logic proto_err
);
  logic       req_sync;
  logic       entering;
  logic       viol_now;
  slp_state_e state;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sleep_req), .q_sync(req_sync)
  );

  slp_fsm #(
    .ENTRY_CYCLES(ENTRY_CYCLES),
    .EXIT_CYCLES(EXIT_CYCLES),
    .RECOVERY_CYCLES(RECOVERY_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .state(state)
  );

  slp_guard u_guard (
    .clk(clk), .rst_n(rst_n), .state(state),
    .chip_sel(chip_sel), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .cmd_pass(cmd_pass), .viol_now(viol_now), .proto_err(proto_err)
  );

  assign entering     = (state == ST_ENTER);
  assign asleep       = (state == ST_SLEEP) || (state == ST_EXIT);
  assign access_block = (state != ST_AWAKE);
endmodule

// File: rtl/sleep_sequencer_chk.sv
module sleep_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_sel,
  input logic strobe_a,
  input logic strobe_b,
  input logic asleep,
  input logic access_block,
  input logic cmd_pass,
  input logic proto_err,
  input logic req_sync,
  input logic entering
);
  AST_NO_PASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    access_block |-> !cmd_pass); // R5
  AST_SLEEP_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> access_block); // R5
  AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && req_sync) |=> asleep); // R4
  AST_RECOVERY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> access_block); // R6
  AST_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (access_block && !entering && chip_sel && (strobe_a || strobe_b)) |=> proto_err); // R7
  AST_ENTRY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (entering && chip_sel) |=> proto_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R9
endmodule

bind sleep_sequencer sleep_sequencer_chk u_chk (.*);

// File: tb/sleep_sequencer_test.sv
`timescale 1ns/1ps
module sleep_sequencer_test;
  localparam int REC = 3;

  logic clk = 1'b0;
  logic rst_n, sleep_req, chip_sel, strobe_a, strobe_b;
  logic asleep, access_block, cmd_pass, proto_err;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sleep_sequencer #(.RECOVERY_CYCLES(REC)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_sel(chip_sel),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .asleep(asleep),
    .access_block(access_block), .cmd_pass(cmd_pass), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic cs, input logic sa, input logic sb);
    @(negedge clk);
    chip_sel = cs; strobe_a = sa; strobe_b = sb;
    #0.5;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; sleep_req = 1'b0; chip_sel = 1'b0; strobe_a = 1'b0; strobe_b = 1'b0;
    edges(3);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic go_sleep;
    @(negedge clk);
    sleep_req = 1'b1;
    edges(4);
  endtask

  task automatic t_reset;
    do_reset();
    #1;
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 access_block", access_block, 1'b0);
    chk("R1 proto_err", proto_err, 1'b0);
  endtask

  task automatic t_pass;
    drive(1, 1, 0); chk("R2 cs+strobe_a", cmd_pass, 1'b1);
    drive(1, 0, 1); chk("R2 cs+strobe_b", cmd_pass, 1'b1);
    drive(0, 1, 1); chk("R2 no cs", cmd_pass, 1'b0);
    drive(1, 0, 0); chk("R2 no strobe", cmd_pass, 1'b0);
    drive(0, 0, 0);
  endtask

  task automatic t_enter;
    @(negedge clk);
    sleep_req = 1'b1;
    edges(2);
    chk("R5 not yet blocked", access_block, 1'b0);
    edges(1);
    chk("R3 not asleep at edge 3", asleep, 1'b0);
    chk("R5 blocked during entry", access_block, 1'b1);
    edges(1);
    chk("R3 asleep at edge 4", asleep, 1'b1);
    chk("R5 blocked asleep", access_block, 1'b1);
  endtask

  task automatic t_exit;
    @(negedge clk);
    sleep_req = 1'b0;
    edges(3);
    chk("R4 still asleep at edge 3", asleep, 1'b1);
    edges(1);
    chk("R4 awake at edge 4", asleep, 1'b0);
    chk("R6 recovery inhibits", access_block, 1'b1);
    edges(REC - 1);
    chk("R6 inhibit at last recovery cycle", access_block, 1'b1);
    edges(1);
    chk("R6 inhibit released", access_block, 1'b0);
    chk("R9 no spurious error", proto_err, 1'b0);
  endtask

  task automatic t_sleep_access;
    go_sleep();
    drive(1, 0, 0);
    edges(2);
    chk("R10 cs alone asleep", proto_err, 1'b0);
    drive(1, 1, 0);
    chk("R5 access blocked asleep", cmd_pass, 1'b0);
    edges(1);
    chk("R7 access asleep flagged", proto_err, 1'b1);
    drive(0, 0, 0);
    edges(3);
    chk("R9 sticky", proto_err, 1'b1);
  endtask

  task automatic t_recovery_access;
    do_reset();
    go_sleep();
    @(negedge clk);
    sleep_req = 1'b0;
    edges(4);
    chk("R9 clean before recovery access", proto_err, 1'b0);
    drive(1, 0, 1);
    chk("R5 access blocked in recovery", cmd_pass, 1'b0);
    edges(1);
    chk("R7 access in recovery flagged", proto_err, 1'b1);
    drive(0, 0, 0);
  endtask

  task automatic t_entry_select;
    do_reset();
    @(negedge clk);
    sleep_req = 1'b1;
    edges(3);
    drive(1, 0, 0);
    edges(1);
    chk("R8 select during entry flagged", proto_err, 1'b1);
    drive(0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_enter();
    t_exit();
    t_sleep_access();
    t_recovery_access();
    t_entry_select();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule